// File: doc/BRIEF.md
# Three-Level Segment Driver with Shadowing Correction

This block holds one display line and selects a drive level for each of `NSEG` segment outputs: the high level, the low level or the middle level. A line image prepared by an upstream data path is presented on `nxt_line`. The block copies that image into its line store when `line_pulse` falls. Between two such edges the outputs follow the stored line and the frame-inversion input. In the normal case a segment sits on the high level when its stored bit equals `frame_inv`, and on the low level otherwise.

Four correction strobes can pull individual segments to the middle level for as long as each strobe is high. Two strobes act on the direction of the level the segment is driving. The other two act on segments whose bit does not change between the stored line and the incoming line: one strobe covers segments that stay at 0, the other covers segments that stay at 1. The strobes are meant to be pulsed after the last data of the next line is in place and before the next falling edge of `line_pulse`. An active-low blanking input overrides everything else. The level logic is combinational from the stored line, so a strobe or blanking change reaches the outputs in the same cycle.

`rst_n` is asserted asynchronously and released through a two-stage synchronizer. `line_pulse` is sampled on `clk`.

Top module: `shadow_seg_driver`

## Requirements
- R1: The line store loads `nxt_line` on the first rising clock edge at which `line_pulse` is sampled low after having been sampled high. At every other edge, including the edge where `line_pulse` rises, the store keeps its value.
- R2: The output of segment i is `seg_level[2i+1:2i]`, coded 2'b00 = middle, 2'b01 = high and 2'b10 = low. With `blank_n` high and no strobe active, a segment is high when its stored bit equals `frame_inv`, and low otherwise.
- R3: While `blank_n` is low, every segment is middle, whatever the stored line, `frame_inv`, `nxt_line` and the strobes are.
- R4: While `trim_lo` is high, every segment that would otherwise be low is middle.
- R5: While `trim_hi` is high, every segment that would otherwise be high is middle.
- R6: While `trim_off` is high, every segment whose stored bit is 0 and whose `nxt_line` bit is 0 is middle.
- R7: While `trim_on` is high, every segment whose stored bit is 1 and whose `nxt_line` bit is 1 is middle.
- R8: When several strobes are high together, a segment is middle if any of its conditions holds. The override starts and ends in the same cycle as the strobe, with no added latency.
- R9: Reset clears the line store to all zeros.
- R10: The code 2'b11 never appears on any segment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| nxt_line | input | NSEG | Incoming line image (next-line data) |
| line_pulse | input | 1 | Line pulse; its falling edge loads the line store |
| frame_inv | input | 1 | Frame-inversion signal |
| blank_n | input | 1 | Active-low blanking, highest priority |
| trim_lo | input | 1 | Strobe that moves low-level segments to middle |
| trim_hi | input | 1 | Strobe that moves high-level segments to middle |
| trim_off | input | 1 | Strobe that moves segments unchanged at 0 to middle |
| trim_on | input | 1 | Strobe that moves segments unchanged at 1 to middle |
| seg_level | output | 2*NSEG | Level code per segment, two bits each |

## Verification
The level selection is tried with uniform stored lines against both `frame_inv` values, so that a swapped mapping between high and low shows up. Alternating stored and incoming lines exercise each of the four bit-transition cases (0 to 0, 0 to 1, 1 to 0, 1 to 1) under each strobe in turn, which separates the two direction strobes from the two unchanged-data strobes and shows whether the comparison reads the right source. Random lines, random strobe combinations and occasional blanking, with line loads placed at random, check the combined override rule. The loads are sampled just before and just after the falling-edge cycle, which shows when the capture happens.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

  localparam int unsigned LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    LVL_MID = 2'b00,
    LVL_HI  = 2'b01,
    LVL_LO  = 2'b10
  } lvl_e;

  typedef struct packed {
    logic lo;        // pull low-level segments to middle
    logic hi;        // pull high-level segments to middle
    logic off_same;  // pull segments staying at 0 to middle
    logic on_same;   // pull segments staying at 1 to middle
  } trim_t;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/seg_lp_fall.sv
module seg_lp_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic lp,
  output logic fall
);

  logic lp_q;
  logic lp_d;

  always_comb begin
    lp_d = lp;
    fall = lp_q & ~lp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_q <= 1'b0;
    end else begin
      lp_q <= lp_d;
    end
  end

endmodule

// File: rtl/seg_line_store.sv
module seg_line_store #(
  parameter int unsigned WIDTH = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) begin
      q_d = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/seg_level_cell.sv
module seg_level_cell
  import seg_drv_pkg::*;
(
  input  logic  cur,
  input  logic  nxt,
  input  logic  fr,
  input  logic  blank_n,
  input  trim_t trim,
  output lvl_e  lvl
);

  lvl_e base;
  logic force_mid;

  always_comb begin
    base      = (cur == fr) ? LVL_HI : LVL_LO;
    force_mid = (trim.lo       && (base == LVL_LO)) ||
                (trim.hi       && (base == LVL_HI)) ||
                (trim.off_same && !cur && !nxt)     ||
                (trim.on_same  &&  cur &&  nxt);
    if (!blank_n) begin
      lvl = LVL_MID;
    end else if (force_mid) begin
      lvl = LVL_MID;
    end else begin
      lvl = base;
    end
  end

endmodule

// File: rtl/shadow_seg_driver.sv
module shadow_seg_driver
  import seg_drv_pkg::*;
#(
  parameter int unsigned NSEG = 240
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSEG-1:0]       nxt_line,
  input  logic                  line_pulse,
  input  logic                  frame_inv,
  input  logic                  blank_n,
  input  logic                  trim_lo,
  input  logic                  trim_hi,
  input  logic                  trim_off,
  input  logic                  trim_on,
  output logic [LVL_W*NSEG-1:0] seg_level
);

  localparam int unsigned OUT_W = LVL_W * NSEG;

  logic            rst_ns;
  logic            lp_fall;
  logic [NSEG-1:0] line_q;
  trim_t           trim;

  always_comb begin
    trim.lo       = trim_lo;
    trim.hi       = trim_hi;
    trim.off_same = trim_off;
    trim.on_same  = trim_on;
  end

  seg_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_ns)
  );

  seg_lp_fall u_lp (
    .clk   (clk),
    .rst_n (rst_ns),
    .lp    (line_pulse),
    .fall  (lp_fall)
  );

  seg_line_store #(.WIDTH(NSEG)) u_store (
    .clk   (clk),
    .rst_n (rst_ns),
    .load  (lp_fall),
    .d     (nxt_line),
    .q     (line_q)
  );

  logic [OUT_W-1:0] lvl_flat;

  for (genvar gi = 0; gi < NSEG; gi++) begin : g_seg
    lvl_e lvl;
    seg_level_cell u_cell (
      .cur     (line_q[gi]),
      .nxt     (nxt_line[gi]),
      .fr      (frame_inv),
      .blank_n (blank_n),
      .trim    (trim),
      .lvl     (lvl)
    );
    assign lvl_flat[LVL_W*gi +: LVL_W] = lvl;
  end

  assign seg_level = lvl_flat;

endmodule

// File: rtl/seg_drv_checker.sv
module seg_drv_checker #(
  parameter int unsigned NSEG = 240
) (
  input logic              clk,
  input logic              rst_ns,
  input logic [NSEG-1:0]   nxt_line,
  input logic              line_pulse,
  input logic              frame_inv,
  input logic              blank_n,
  input logic              trim_lo,
  input logic              trim_hi,
  input logic              trim_off,
  input logic              trim_on,
  input logic [NSEG-1:0]   line_q,
  input logic [2*NSEG-1:0] seg_level
);

  // R1: capture on falling line pulse, hold otherwise
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(line_pulse) |=> (line_q == $past(nxt_line)));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    !$fell(line_pulse) |=> $stable(line_q));

  for (genvar gi = 0; gi < NSEG; gi++) begin : g_chk
    logic [1:0] lv;
    logic       cur;
    logic       nx;
    assign lv  = seg_level[2*gi +: 2];
    assign cur = line_q[gi];
    assign nx  = nxt_line[gi];

    p_map_r2: assert property (@(posedge clk) disable iff (!rst_ns)
      (blank_n && !trim_lo && !trim_hi && !trim_off && !trim_on)
        |-> (lv == ((cur == frame_inv) ? 2'b01 : 2'b10)));
    p_blank_r3: assert property (@(posedge clk) disable iff (!rst_ns)
      !blank_n |-> (lv == 2'b00));
    p_lo_r4: assert property (@(posedge clk) disable iff (!rst_ns)
      trim_lo |-> (lv != 2'b10));
    p_hi_r5: assert property (@(posedge clk) disable iff (!rst_ns)
      trim_hi |-> (lv != 2'b01));
    p_off_r6: assert property (@(posedge clk) disable iff (!rst_ns)
      (trim_off && !cur && !nx) |-> (lv == 2'b00));
    p_on_r7: assert property (@(posedge clk) disable iff (!rst_ns)
      (trim_on && cur && nx) |-> (lv == 2'b00));
    p_code_r10: assert property (@(posedge clk) disable iff (!rst_ns)
      lv != 2'b11);
  end

endmodule

bind shadow_seg_driver seg_drv_checker #(.NSEG(NSEG)) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .nxt_line   (nxt_line),
  .line_pulse (line_pulse),
  .frame_inv  (frame_inv),
  .blank_n    (blank_n),
  .trim_lo    (trim_lo),
  .trim_hi    (trim_hi),
  .trim_off   (trim_off),
  .trim_on    (trim_on),
  .line_q     (line_q),
  .seg_level  (seg_level)
);

// File: tb/shadow_seg_driver_bench.sv
module shadow_seg_driver_bench;

  localparam int unsigned N = 240;

  logic           clk;
  logic           rst_n;
  logic [N-1:0]   nxt_line;
  logic           line_pulse;
  logic           frame_inv;
  logic           blank_n;
  logic           trim_lo, trim_hi, trim_off, trim_on;
  logic [2*N-1:0] seg_level;

  logic [N-1:0]   model_line;
  int unsigned    n_checks;
  int unsigned    n_fail;
  bit             done;

  shadow_seg_driver #(.NSEG(N)) u_shadow_seg_driver (
    .clk        (clk),
    .rst_n      (rst_n),
    .nxt_line   (nxt_line),
    .line_pulse (line_pulse),
    .frame_inv  (frame_inv),
    .blank_n    (blank_n),
    .trim_lo    (trim_lo),
    .trim_hi    (trim_hi),
    .trim_off   (trim_off),
    .trim_on    (trim_on),
    .seg_level  (seg_level)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Expected levels from the requirements: 00 middle, 01 high, 10 low
  function automatic logic [2*N-1:0] exp_levels(
    input logic [N-1:0] cur, input logic [N-1:0] nx, input logic fr,
    input logic bl, input logic lo, input logic hi, input logic off, input logic on);
    logic [2*N-1:0] e;
    for (int i = 0; i < N; i++) begin
      logic [1:0] b;
      logic       m;
      b = (cur[i] == fr) ? 2'b01 : 2'b10;
      m = (lo && b == 2'b10) || (hi && b == 2'b01) ||
          (off && !cur[i] && !nx[i]) || (on && cur[i] && nx[i]);
      e[2*i +: 2] = (!bl || m) ? 2'b00 : b;
    end
    return e;
  endfunction

  function automatic logic [N-1:0] rand_vec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'($urandom_range(0, 1));
    return v;
  endfunction

  function automatic logic [N-1:0] alt_vec(input logic phase);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = 1'(i % 2) ^ phase;
    return v;
  endfunction

  task automatic check_vec(input string req, input logic [2*N-1:0] exp);
    n_checks++;
    if (seg_level !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, seg_level, exp);
    end
  endtask

  task automatic check_model(input string req);
    check_vec(req, exp_levels(model_line, nxt_line, frame_inv, blank_n,
                              trim_lo, trim_hi, trim_off, trim_on));
  endtask

  task automatic set_in(input logic bl, input logic fr, input logic lo,
                        input logic hi, input logic off, input logic on);
    blank_n = bl; frame_inv = fr;
    trim_lo = lo; trim_hi = hi; trim_off = off; trim_on = on;
  endtask

  // Load a line through a full pulse; R1 checked before and after capture
  task automatic load_line(input logic [N-1:0] d);
    @(negedge clk);
    nxt_line   = d;
    line_pulse = 1'b1;
    @(negedge clk);
    #1 check_model("R1 no capture on rising pulse");
    line_pulse = 1'b0;
    #1 check_model("R1 no capture before falling edge is clocked");
    @(negedge clk);
    model_line = d;
    #1 check_model("R1 captured after falling edge");
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ones_v;
    n_checks = 0;
    n_fail   = 0;
    ones_v   = '1;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; nxt_line = '0; line_pulse = 1'b0;
    set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    model_line = '0;

    // R9: cleared store, FR high, data 0 -> all low
    #5 check_vec("R9 reset store zero", {N{2'b10}});
    blank_n = 1'b0;
    #1 check_vec("R3 blank during reset", '0);
    blank_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check_vec("R9 store zero after release", {N{2'b10}});

    // R2: uniform lines with both frame values
    load_line(ones_v);
    @(negedge clk); set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    #1 check_vec("R2 data1 fr1 high", {N{2'b01}});
    @(negedge clk); frame_inv = 1'b0;
    #1 check_vec("R2 data1 fr0 low", {N{2'b10}});
    load_line('0);
    @(negedge clk); frame_inv = 1'b0;
    #1 check_vec("R2 data0 fr0 high", {N{2'b01}});
    @(negedge clk); frame_inv = 1'b1;
    #1 check_vec("R2 data0 fr1 low", {N{2'b10}});

    // R3: blank overrides strobes and data
    @(negedge clk); set_in(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    #1 check_vec("R3 blank over all", '0);

    // R4..R7 with alternating stored line, incoming line covering all transitions
    load_line(alt_vec(1'b0));
    @(negedge clk);
    nxt_line = {N/4{4'b0011}};
    set_in(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    #1 check_model("R4 trim_lo");
    @(negedge clk); set_in(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    #1 check_model("R5 trim_hi");
    @(negedge clk); set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    #1 check_model("R6 trim_off");
    @(negedge clk); set_in(1'b1, 1'b0, 1'b0, 1'b0, 0'b0 | 1'b0, 1'b1);
    #1 check_model("R7 trim_on");
    @(negedge clk); set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    #1 check_model("R8 override ends with strobe");

    // R6/R7 spot: unchanged all-zero and all-one lines
    load_line('0);
    @(negedge clk); set_in(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    #1 check_vec("R6 unchanged zeros middle", '0);
    @(negedge clk); nxt_line = ones_v;
    #1 check_vec("R6 changed zeros not middle", {N{2'b01}});
    load_line(ones_v);
    @(negedge clk); set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    #1 check_vec("R7 unchanged ones middle", '0);
    @(negedge clk); set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    #1 check_vec("R8 release same cycle", {N{2'b01}});

    // R8 combined strobes and random patterns, R10 code legality
    for (int it = 0; it < 300; it++) begin
      if ((it % 7) == 0) load_line(rand_vec());
      @(negedge clk);
      nxt_line = rand_vec();
      set_in(($urandom_range(0, 9) != 0), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      #1 check_model("R8 random strobes");
      n_checks++;
      for (int i = 0; i < N; i++) begin
        if (seg_level[2*i +: 2] == 2'b11) begin
          n_fail++;
          $display("FAIL R10 seg %0d: got 11 expected legal code", i);
          break;
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule